// File: doc/BRIEF.md
# Watchdog Timer with Cascaded Prescalers

This block is a watchdog that runs from a slow on-chip oscillator clock. The clock goes through a divide-by-4 stage that cannot be changed. It then passes a coarse prescaler and a fine prescaler, and finally reaches an 8-bit time-out counter. The coarse prescaler divides by a power of eight and the fine one by any whole ratio from 1 to 16. When the counter wraps past its top value, a time-out occurs.

Software keeps the watchdog quiet by pulsing the clear strobe often enough. The strobe restarts the counter and both prescalers together. If the core is running when a time-out comes, the block asks for a device reset. If the core is asleep or idle, the block asks for a wake-up instead. Sticky flags record that a time-out happened and, on a wake-up, which low-power state the core was in. These flags stay set until the status-clear input is pulsed.

All logic runs in the slow clock domain, and `clk` is that oscillator.

Top module: `dualPrescaleWatchdog`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, all five outputs read 0.
- R2: The total division is 4 x A x B x 256 clocks, so with `psaCode`=00 and `psbCode`=0000 a time-out comes every 1024 cycles. When counting starts (the first rising edge that samples `enable`=1 with `clearStrobe`=0 and the chain at zero), the request appears in the 1024th cycle after that point. It then repeats every 1024 cycles for as long as the watchdog is not cleared.
- R3: The coarse ratio A is picked by the 2-bit `psaCode`: 0 gives 1, 1 gives 8, 2 gives 64 and 3 gives 512.
- R4: The fine ratio B is `psbCode`+1 for the 4-bit `psbCode`, which covers 1 to 16.
- R5: An edge that samples `clearStrobe`=1 returns the fixed divider, both prescalers and the counter to zero, so a full period starts over. This holds even on the edge where a time-out would have happened, and that time-out is then dropped.
- R6: A time-out while `sleepMode` and `idleMode` are both 0 gives a `resetReq` pulse one cycle long, with `wakeReq` staying at 0.
- R7: A time-out while `sleepMode` or `idleMode` is 1 gives a `wakeReq` pulse one cycle long, with `resetReq` staying at 0.
- R8: Every time-out sets `timeoutFlag`, and the flag holds its value until it is cleared.
- R9: A wake-up with `sleepMode`=1 sets `sleepFlag`. A wake-up with only `idleMode`=1 sets `idleFlag`. When both modes are 1, only `sleepFlag` is set.
- R10: While `enable` is 0, the whole chain is held at zero and neither request is raised. When `enable` returns to 1, a full period starts.
- R11: An edge that samples `statusClear`=1 clears all three flags. If a time-out falls on that same edge, the flags it sets win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow oscillator clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Watchdog enable |
| clearStrobe | input | 1 | Restart the counter and all prescalers |
| psaCode | input | 2 | Coarse ratio select (1, 8, 64, 512) |
| psbCode | input | 4 | Fine ratio select (code + 1) |
| sleepMode | input | 1 | Core is in sleep |
| idleMode | input | 1 | Core is idle |
| statusClear | input | 1 | Clear the sticky flags |
| resetReq | output | 1 | Single-cycle device reset request |
| wakeReq | output | 1 | Single-cycle wake-up request |
| timeoutFlag | output | 1 | Sticky time-out flag |
| sleepFlag | output | 1 | Sticky woken-from-sleep flag |
| idleFlag | output | 1 | Sticky woken-from-idle flag |

## Verification
Two pairs of events can fall on the same clock edge. In the first, a clear strobe arrives on the edge where the counter would wrap. The bench raises the strobe in the cycle just before a time-out it has predicted. It then expects no pulse at the old due cycle and a full fresh period measured from the strobe. In the second, a status clear lands on a time-out edge. The bench judges this by reading `timeoutFlag` right after the request pulse and expects it to still be set.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Strobes from the control section to the division chain.
  typedef struct packed {
    logic zero;   // force every stage of the chain to zero
    logic run;    // advance the first stage this cycle
  } chainCtl_t;

endpackage

// File: rtl/wdtDivStage.sv
module wdtDivStage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         zero,
  input  logic         stepIn,
  input  logic [W-1:0] limit,
  output logic         stepOut
);

  logic [W-1:0] count;
  logic         atLimit;

  assign atLimit = (count == limit);
  assign stepOut = stepIn & atLimit & ~zero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (zero) begin
      count <= '0;
    end else if (stepIn) begin
      count <= atLimit ? '0 : count + 1'b1;
    end
  end

endmodule

// File: rtl/wdtDatapath.sv
module wdtDatapath
  import wdt_pkg::*;
#(
  parameter int FIX_LOG2      = 2,
  parameter int PSA_CODE_W    = 2,
  parameter int PSA_STEP_LOG2 = 3,
  parameter int PSB_W         = 4,
  parameter int CNT_W         = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  chainCtl_t             ctl,
  input  logic [PSA_CODE_W-1:0] psaCode,
  input  logic [PSB_W-1:0]      psbCode,
  output logic                  overflow
);

  localparam int PSA_MAX_CODE = (1 << PSA_CODE_W) - 1;
  localparam int PSA_W        = (PSA_STEP_LOG2 * PSA_MAX_CODE > 0) ? PSA_STEP_LOG2 * PSA_MAX_CODE : 1;

  logic             fixStep;
  logic             psaStep;
  logic             psbStep;
  logic [PSA_W:0]   psaRatio;
  logic [PSA_W-1:0] psaLimit;

  // Coarse ratio is 2^(step*code); the stage counts to ratio-1.
  always_comb begin
    psaRatio = (PSA_W + 1)'(1) << (PSA_STEP_LOG2 * int'(psaCode));
    psaLimit = PSA_W'(psaRatio - (PSA_W + 1)'(1));
  end

  generate
    if (FIX_LOG2 > 0) begin : g_fixDiv
      wdtDivStage #(.W(FIX_LOG2)) uFix (
        .clk     (clk),
        .rstN    (rstN),
        .zero    (ctl.zero),
        .stepIn  (ctl.run),
        .limit   ({FIX_LOG2{1'b1}}),
        .stepOut (fixStep)
      );
    end else begin : g_fixPass
      assign fixStep = ctl.run;
    end
  endgenerate

  wdtDivStage #(.W(PSA_W)) uPsa (
    .clk     (clk),
    .rstN    (rstN),
    .zero    (ctl.zero),
    .stepIn  (fixStep),
    .limit   (psaLimit),
    .stepOut (psaStep)
  );

  wdtDivStage #(.W(PSB_W)) uPsb (
    .clk     (clk),
    .rstN    (rstN),
    .zero    (ctl.zero),
    .stepIn  (psaStep),
    .limit   (psbCode),
    .stepOut (psbStep)
  );

  wdtDivStage #(.W(CNT_W)) uCnt (
    .clk     (clk),
    .rstN    (rstN),
    .zero    (ctl.zero),
    .stepIn  (psbStep),
    .limit   ({CNT_W{1'b1}}),
    .stepOut (overflow)
  );

endmodule

// File: rtl/wdtControl.sv
module wdtControl
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      clearStrobe,
  input  logic      sleepMode,
  input  logic      idleMode,
  input  logic      statusClear,
  input  logic      overflow,
  output chainCtl_t ctl,
  output logic      resetReq,
  output logic      wakeReq,
  output logic      timeoutFlag,
  output logic      sleepFlag,
  output logic      idleFlag
);

  logic lowPower;
  logic hitSleep;
  logic hitIdle;

  always_comb begin
    ctl.zero = clearStrobe | ~enable;
    ctl.run  = enable & ~clearStrobe;
  end

  assign lowPower = sleepMode | idleMode;
  assign hitSleep = overflow & sleepMode;
  assign hitIdle  = overflow & idleMode & ~sleepMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetReq    <= 1'b0;
      wakeReq     <= 1'b0;
      timeoutFlag <= 1'b0;
      sleepFlag   <= 1'b0;
      idleFlag    <= 1'b0;
    end else begin
      resetReq <= overflow & ~lowPower;
      wakeReq  <= overflow & lowPower;

      if (overflow)         timeoutFlag <= 1'b1;
      else if (statusClear) timeoutFlag <= 1'b0;

      if (hitSleep)         sleepFlag <= 1'b1;
      else if (statusClear) sleepFlag <= 1'b0;

      if (hitIdle)          idleFlag <= 1'b1;
      else if (statusClear) idleFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/dualPrescaleWatchdog.sv
module dualPrescaleWatchdog
  import wdt_pkg::*;
#(
  parameter int FIX_LOG2      = 2,
  parameter int PSA_CODE_W    = 2,
  parameter int PSA_STEP_LOG2 = 3,
  parameter int PSB_W         = 4,
  parameter int CNT_W         = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic                  clearStrobe,
  input  logic [PSA_CODE_W-1:0] psaCode,
  input  logic [PSB_W-1:0]      psbCode,
  input  logic                  sleepMode,
  input  logic                  idleMode,
  input  logic                  statusClear,
  output logic                  resetReq,
  output logic                  wakeReq,
  output logic                  timeoutFlag,
  output logic                  sleepFlag,
  output logic                  idleFlag
);

  chainCtl_t ctl;
  logic      overflow;

  wdtControl uCtl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .clearStrobe (clearStrobe),
    .sleepMode   (sleepMode),
    .idleMode    (idleMode),
    .statusClear (statusClear),
    .overflow    (overflow),
    .ctl         (ctl),
    .resetReq    (resetReq),
    .wakeReq     (wakeReq),
    .timeoutFlag (timeoutFlag),
    .sleepFlag   (sleepFlag),
    .idleFlag    (idleFlag)
  );

  wdtDatapath #(
    .FIX_LOG2      (FIX_LOG2),
    .PSA_CODE_W    (PSA_CODE_W),
    .PSA_STEP_LOG2 (PSA_STEP_LOG2),
    .PSB_W         (PSB_W),
    .CNT_W         (CNT_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .psaCode  (psaCode),
    .psbCode  (psbCode),
    .overflow (overflow)
  );

endmodule

// File: rtl/dualPrescaleWatchdogChk.sv
module dualPrescaleWatchdogChk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic clearStrobe,
  input logic sleepMode,
  input logic idleMode,
  input logic statusClear,
  input logic resetReq,
  input logic wakeReq,
  input logic timeoutFlag,
  input logic sleepFlag,
  input logic idleFlag
);

  a_r6_reset_single: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  a_r7_wake_single: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |=> !wakeReq);

  a_r7_requests_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({resetReq, wakeReq}));

  a_r7_no_reset_low_power: assert property (@(posedge clk) disable iff (!rstN)
    (sleepMode || idleMode) |=> !resetReq);

  a_r6_no_wake_running: assert property (@(posedge clk) disable iff (!rstN)
    !(sleepMode || idleMode) |=> !wakeReq);

  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!resetReq && !wakeReq));

  a_r5_clear_quiet: assert property (@(posedge clk) disable iff (!rstN)
    clearStrobe |=> (!resetReq && !wakeReq));

  a_r8_flag_with_request: assert property (@(posedge clk) disable iff (!rstN)
    (resetReq || wakeReq) |-> timeoutFlag);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !statusClear) |=> timeoutFlag);

  a_r9_sleep_flag: assert property (@(posedge clk) disable iff (!rstN)
    (wakeReq && $past(sleepMode)) |-> sleepFlag);

  a_r9_idle_flag: assert property (@(posedge clk) disable iff (!rstN)
    (wakeReq && $past(idleMode) && !$past(sleepMode)) |-> idleFlag);

  a_r11_status_clear: assert property (@(posedge clk) disable iff (!rstN)
    ($past(statusClear) && !resetReq && !wakeReq) |-> (!timeoutFlag && !sleepFlag && !idleFlag));

endmodule

bind dualPrescaleWatchdog dualPrescaleWatchdogChk uChk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .clearStrobe (clearStrobe),
  .sleepMode   (sleepMode),
  .idleMode    (idleMode),
  .statusClear (statusClear),
  .resetReq    (resetReq),
  .wakeReq     (wakeReq),
  .timeoutFlag (timeoutFlag),
  .sleepFlag   (sleepFlag),
  .idleFlag    (idleFlag)
);

// File: tb/tb_dualPrescaleWatchdog.sv
module tb_dualPrescaleWatchdog;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b1;
  logic       clearStrobe = 1'b0;
  logic [1:0] psaCode = 2'd0;
  logic [3:0] psbCode = 4'd0;
  logic       sleepMode = 1'b0;
  logic       idleMode = 1'b0;
  logic       statusClear = 1'b0;
  logic       resetReq, wakeReq, timeoutFlag, sleepFlag, idleFlag;

  always #10 clk = ~clk;

  dualPrescaleWatchdog dut (
    .clk(clk), .rstN(rstN), .enable(enable), .clearStrobe(clearStrobe),
    .psaCode(psaCode), .psbCode(psbCode), .sleepMode(sleepMode),
    .idleMode(idleMode), .statusClear(statusClear), .resetReq(resetReq),
    .wakeReq(wakeReq), .timeoutFlag(timeoutFlag), .sleepFlag(sleepFlag),
    .idleFlag(idleFlag)
  );

  typedef struct {
    int    kind;   // 0 = reset request, 1 = wake request
    int    due;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  int  cyc = 0;
  int  compared = 0;
  int  mismatched = 0;
  bit  summaryDone = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, string what, int actual, int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic printSummary();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    end
  endtask

  // Monitor: compare every request pulse against the expectation queue.
  always @(negedge clk) begin
    if (rstN) begin
      if (expQ.size() > 0 && expQ[0].due < cyc) begin
        expItem_t lost;
        lost = expQ.pop_front();
        compared++;
        mismatched++;
        $display("FAIL %s missing pulse: actual none expected kind %0d at cycle %0d",
                 lost.req, lost.kind, lost.due);
      end
      if (resetReq || wakeReq) begin
        int kind;
        kind = wakeReq ? 1 : 0;
        compared++;
        if (expQ.size() == 0) begin
          mismatched++;
          $display("FAIL R5/R10 unexpected pulse: actual kind %0d at cycle %0d expected none",
                   kind, cyc);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          if (it.kind != kind || it.due != cyc) begin
            mismatched++;
            $display("FAIL %s pulse: actual kind %0d cycle %0d expected kind %0d cycle %0d",
                     it.req, kind, cyc, it.kind, it.due);
          end
        end
      end
    end
  end

  function automatic int periodOf(int a, int b);
    return 4 * (1 << (3 * a)) * (b + 1) * 256;
  endfunction

  task automatic expectAt(int kind, int delta, string req);
    expItem_t it;
    it.kind = kind;
    it.due  = cyc + delta;
    it.req  = req;
    expQ.push_back(it);
  endtask

  // Leaves the caller at the negedge where counting starts.
  task automatic restart();
    @(negedge clk) clearStrobe = 1'b1;
    @(negedge clk) clearStrobe = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
  endtask

  task automatic clearFlags();
    @(negedge clk) statusClear = 1'b1;
    @(negedge clk) statusClear = 1'b0;
  endtask

  task automatic waitCycle(int t);
    while (cyc < t) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!summaryDone) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual run still busy expected finished");
      printSummary();
      $finish;
    end
  end

  initial begin
    int start;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset and just after
    check("R1", "resetReq in reset", resetReq, 0);
    check("R1", "flags in reset", {timeoutFlag, sleepFlag, idleFlag}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "outputs after reset", {resetReq, wakeReq, timeoutFlag, sleepFlag, idleFlag}, 0);

    // R2 / R6: base period, repeating reset requests
    restart();
    expectAt(0, periodOf(0, 0), "R2");
    expectAt(0, 2 * periodOf(0, 0), "R6");
    drain();
    check("R8", "timeoutFlag after reset request", timeoutFlag, 1);
    check("R9", "sleep/idle flags after reset request", {sleepFlag, idleFlag}, 0);
    clearFlags();
    check("R11", "flags after status clear", {timeoutFlag, sleepFlag, idleFlag}, 0);

    // R4: fine ratio code 3 -> divide by 4
    psbCode = 4'd3;
    restart();
    expectAt(0, periodOf(0, 3), "R4");
    drain();

    // R3: coarse code 1 -> 8, code 2 -> 64
    psbCode = 4'd0;
    psaCode = 2'd1;
    restart();
    expectAt(0, periodOf(1, 0), "R3");
    drain();
    psaCode = 2'd2;
    restart();
    expectAt(0, periodOf(2, 0), "R3");
    drain();

    // R7 / R9: wake from sleep
    psaCode = 2'd0;
    clearFlags();
    sleepMode = 1'b1;
    restart();
    expectAt(1, periodOf(0, 0), "R7");
    drain();
    check("R9", "sleepFlag after sleep wake", sleepFlag, 1);
    check("R9", "idleFlag after sleep wake", idleFlag, 0);
    check("R8", "timeoutFlag after wake", timeoutFlag, 1);

    // R9: wake from idle
    sleepMode = 1'b0;
    idleMode = 1'b1;
    clearFlags();
    restart();
    expectAt(1, periodOf(0, 0), "R7");
    drain();
    check("R9", "idleFlag after idle wake", idleFlag, 1);
    check("R9", "sleepFlag after idle wake", sleepFlag, 0);

    // R9: both modes -> sleep flag only
    sleepMode = 1'b1;
    clearFlags();
    restart();
    expectAt(1, periodOf(0, 0), "R9");
    drain();
    check("R9", "flags with both modes", {sleepFlag, idleFlag}, 2'b10);
    sleepMode = 1'b0;
    idleMode = 1'b0;

    // R5: clear mid-period restarts a full period
    restart();
    repeat (500) @(negedge clk);
    restart();
    expectAt(0, periodOf(0, 0), "R5");
    drain();

    // R5: clear on the wrap edge suppresses that time-out
    restart();
    start = cyc;
    waitCycle(start + periodOf(0, 0) - 1);
    clearStrobe = 1'b1;
    @(negedge clk) clearStrobe = 1'b0;
    expectAt(0, periodOf(0, 0), "R5");
    drain();

    // R10: disable holds the chain; re-enable gives a full period
    @(negedge clk) enable = 1'b0;
    repeat (3000) @(negedge clk);
    check("R10", "requests while disabled", {resetReq, wakeReq}, 0);
    enable = 1'b1;
    expectAt(0, periodOf(0, 0), "R10");
    drain();

    // R11: status clear coinciding with a time-out keeps the flag set
    clearFlags();
    check("R11", "flags cleared before coincidence", timeoutFlag, 0);
    restart();
    start = cyc;
    expectAt(0, periodOf(0, 0), "R11");
    waitCycle(start + periodOf(0, 0) - 1);
    statusClear = 1'b1;
    @(negedge clk) statusClear = 1'b0;
    drain();
    check("R11", "timeoutFlag when set meets clear", timeoutFlag, 1);

    @(negedge clk) enable = 1'b0;
    repeat (5) @(negedge clk);
    if (expQ.size() != 0) begin
      compared++;
      mismatched++;
      $display("FAIL R2 leftover expectations: actual %0d expected 0", expQ.size());
    end
    printSummary();
    $finish;
  end

endmodule